// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block sits between an I2C/SMBus master and the open-drain SCL/SDA pads. It frees a slave whose state machine has locked up, which happens most often after the slave's I/O supply has dropped during a low-power state. A resume event or an explicit start launches the sequence. The block takes the pads into direct drive and clocks SCL eight times while SDA stays released. It then hands the pads back to the controller and asks the controller for a throwaway read, followed by a check read. An acknowledged check read ends the sequence as a success.

A failed attempt is repeated up to a parameterised limit. When the limit is used up, the block removes the slave's power enable for a timed interval, restores it and makes one final attempt. Phase and power-off durations are derived from the clock frequency parameter. The block raises a one-cycle done or fail pulse at the end and keeps busy high for the whole run.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, busy, done, fail, scl_oe_o, sda_oe_o and rd_req_o are 0, and pad_sel_o and slave_pwr_en_o are 1 (pad_sel_o = 1 means the controller owns the pads).
- R2: A start_i or resume_i pulse while idle launches a run. pad_sel_o goes to 0 (direct drive) and both lines stay released for one phase (PHASE_US of clock time) before the first SCL pulse.
- R3: Each attempt drives exactly NUM_PULSES (default 8) SCL low pulses. Each low phase and each released phase between pulses lasts exactly one phase time. sda_oe_o is never asserted.
- R4: After the last pulse, the released phase plus one further settle phase elapse (two phases in total). Then pad_sel_o returns to 1. rd_req_o is never high while pad_sel_o is 0, and scl_oe_o is never high while pad_sel_o is 1.
- R5: An attempt whose bus is free issues a dummy read to 7-bit address 0x1A, followed by a check read to the same address. The acknowledge result of the dummy read has no effect.
- R6: If SDA is sensed low while SCL is released at the end of the settle phase, the attempt fails without issuing any read.
- R7: An acknowledged check read ends the run with a done pulse lasting exactly one cycle. busy falls in that cycle.
- R8: After RETRIES (default 3) failed attempts, slave_pwr_en_o goes low for exactly PWROFF_MS of clock time and then returns high. A success before that limit causes no power cycle.
- R9: After a power cycle the block makes exactly one more attempt. A failure of that attempt ends the run with a one-cycle fail pulse; its success ends the run with done.
- R10: start_i and resume_i are ignored while a run is in progress.
- R11: busy is high from the cycle after launch until the done or fail cycle, including the power-off wait. done and fail are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a recovery run |
| resume_i | input | 1 | Power-domain resume event; launches a run |
| scl_i | input | 1 | Sensed SCL pad level |
| sda_i | input | 1 | Sensed SDA pad level |
| scl_oe_o | output | 1 | Pull SCL low in direct-drive mode |
| sda_oe_o | output | 1 | Pull SDA low in direct-drive mode (held released) |
| pad_sel_o | output | 1 | 1: pads owned by the I2C controller, 0: direct drive |
| rd_req_o | output | 1 | Read request to the controller, held until rd_done_i |
| rd_addr_o | output | 7 | 7-bit target address of the requested read |
| rd_done_i | input | 1 | One-cycle completion of a requested read |
| rd_ack_i | input | 1 | Read was acknowledged, valid with rd_done_i |
| slave_pwr_en_o | output | 1 | Power enable for the slave |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse: bus recovered |
| fail_o | output | 1 | One-cycle pulse: recovery failed after power cycle |

## Verification
The hardest behaviour to reach is the power-cycle path and the single attempt that follows it. It needs RETRIES consecutive failed attempts, and it must be reached both through a stuck SDA line and through refused check reads. The bench models the open-drain pads, with a switch that holds SDA low. Its controller model answers reads and acknowledges only from a chosen read index onward. This lets it place the first success at attempt two, at the post-power attempt, or nowhere. Timing parameters are shortened so that the power-off interval fits in a short run while its exact length is still measured.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREP,
        ST_LOW,
        ST_HIGH,
        ST_SETTLE,
        ST_DUMMY,
        ST_CHECK,
        ST_MISS,
        ST_PWROFF
    } unstick_state_e;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign pipe_d[g] = d_i;
        end else begin : g_next
            assign pipe_d[g] = pipe_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)           cnt_d = val_i;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
    import i2c_unstick_pkg::*;
#(
    parameter int         CLK_HZ      = 100_000_000,
    parameter int         PHASE_US    = 5,
    parameter int         PWROFF_MS   = 100,
    parameter int         RETRIES     = 3,
    parameter int         NUM_PULSES  = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h1A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       resume_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    output logic       pad_sel_o,
    output logic       rd_req_o,
    output logic [6:0] rd_addr_o,
    input  logic       rd_done_i,
    input  logic       rd_ack_i,
    output logic       slave_pwr_en_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       fail_o
);
    localparam int PHASE_RAW = (CLK_HZ / 1_000_000) * PHASE_US;
    localparam int PHASE_CYC = (PHASE_RAW < 1) ? 1 : PHASE_RAW;
    localparam int OFF_RAW   = (CLK_HZ / 1000) * PWROFF_MS;
    localparam int OFF_CYC   = (OFF_RAW < 1) ? 1 : OFF_RAW;
    localparam int MAX_CYC   = (OFF_CYC > PHASE_CYC) ? OFF_CYC : PHASE_CYC;
    localparam int TW        = $clog2(MAX_CYC + 1);
    localparam int TRW       = (RETRIES > 1) ? $clog2(RETRIES) : 1;
    localparam int PCW       = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;

    typedef struct packed {
        unstick_state_e    state;
        logic [TRW-1:0]    tries;
        logic [PCW-1:0]    pulses;
        logic              post_pwr;
        logic              done;
        logic              fail;
    } regs_t;

    regs_t         r_d, r_q;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic [1:0]    pads_s;
    logic          bus_stuck;

    unstick_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(pads_s)
    );

    unstick_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
    );

    // stuck: SCL released yet SDA held low
    assign bus_stuck = pads_s[1] && !pads_s[0];

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = TW'(PHASE_CYC - 1);
        unique case (r_q.state)
            ST_IDLE: if (start_i || resume_i) begin
                r_d.state    = ST_PREP;
                r_d.tries    = '0;
                r_d.pulses   = '0;
                r_d.post_pwr = 1'b0;
                tmr_load     = 1'b1;
            end
            ST_PREP: if (tmr_zero) begin
                r_d.state = ST_LOW;
                tmr_load  = 1'b1;
            end
            ST_LOW: if (tmr_zero) begin
                r_d.state = ST_HIGH;
                tmr_load  = 1'b1;
            end
            ST_HIGH: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (r_q.pulses == PCW'(NUM_PULSES - 1)) begin
                    r_d.state  = ST_SETTLE;
                    r_d.pulses = '0;
                end else begin
                    r_d.state  = ST_LOW;
                    r_d.pulses = r_q.pulses + 1'b1;
                end
            end
            ST_SETTLE: if (tmr_zero) begin
                r_d.state = bus_stuck ? ST_MISS : ST_DUMMY;
            end
            ST_DUMMY: if (rd_done_i) begin
                r_d.state = ST_CHECK;
            end
            ST_CHECK: if (rd_done_i) begin
                if (rd_ack_i) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.state = ST_MISS;
                end
            end
            ST_MISS: begin
                if (r_q.post_pwr) begin
                    r_d.state = ST_IDLE;
                    r_d.fail  = 1'b1;
                end else if (r_q.tries == TRW'(RETRIES - 1)) begin
                    r_d.state = ST_PWROFF;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(OFF_CYC - 1);
                end else begin
                    r_d.state  = ST_PREP;
                    r_d.tries  = r_q.tries + 1'b1;
                    r_d.pulses = '0;
                    tmr_load   = 1'b1;
                end
            end
            ST_PWROFF: if (tmr_zero) begin
                r_d.state    = ST_PREP;
                r_d.post_pwr = 1'b1;
                r_d.pulses   = '0;
                tmr_load     = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o         = (r_q.state != ST_IDLE);
    assign pad_sel_o      = !(r_q.state inside {ST_PREP, ST_LOW, ST_HIGH, ST_SETTLE});
    assign scl_oe_o       = (r_q.state == ST_LOW);
    assign sda_oe_o       = 1'b0;
    assign rd_req_o       = (r_q.state inside {ST_DUMMY, ST_CHECK});
    assign rd_addr_o      = DEV_ADDR;
    assign slave_pwr_en_o = (r_q.state != ST_PWROFF);
    assign done_o         = r_q.done;
    assign fail_o         = r_q.fail;

    assert_end_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));
    assert_pwr_off_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_pwr_en_o |-> busy_o);
    assert_read_handback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> pad_sel_o);
    assert_scl_direct_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe_o |-> !pad_sel_o);
    assert_fail_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> $past(busy_o));
endmodule

// File: tb/i2c_unstick_test.sv
module i2c_unstick_test;
    localparam int P   = 5;     // phase cycles at 1 MHz, 5 us
    localparam int OFF = 1000;  // power-off cycles at 1 MHz, 1 ms

    logic clk = 0;
    logic rst_n = 0;
    logic start_i = 0, resume_i = 0;
    logic rd_done_i = 0, rd_ack_i = 0;
    logic scl_oe_o, sda_oe_o, pad_sel_o, rd_req_o, slave_pwr_en_o, busy_o, done_o, fail_o;
    logic [6:0] rd_addr_o;
    logic sda_stuck = 0;
    logic scl_line, sda_line;

    assign scl_line = !scl_oe_o;
    assign sda_line = !(sda_oe_o || sda_stuck);

    always #5 clk = ~clk;

    i2c_unstick #(.CLK_HZ(1_000_000), .PHASE_US(5), .PWROFF_MS(1)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .resume_i(resume_i),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
        .pad_sel_o(pad_sel_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_done_i(rd_done_i), .rd_ack_i(rd_ack_i), .slave_pwr_en_o(slave_pwr_en_o),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
    );

    int checks = 0, errors = 0;
    int pulses, timing_bad, sda_drv, mode_bad, done_cnt, fail_cnt, busy_bad;
    int pwr_pulses, pwr_len, pwr_run, low_run, rel_run, reads, addr_bad, ack_from;
    logic scl_prev = 0, pad_prev = 1, pwr_prev = 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_stats();
        pulses = 0; timing_bad = 0; sda_drv = 0; mode_bad = 0; done_cnt = 0;
        fail_cnt = 0; busy_bad = 0; pwr_pulses = 0; pwr_len = 0; reads = 0; addr_bad = 0;
    endtask

    // pad and status monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_oe_o) begin
                if (!scl_prev) begin
                    pulses++;
                    if (rel_run != P) timing_bad++;
                end
                low_run++;
                rel_run = 0;
            end else begin
                if (scl_prev && low_run != P) timing_bad++;
                low_run = 0;
                if (!pad_sel_o) rel_run++;
            end
            if (pad_sel_o && !pad_prev && rel_run != 2 * P) timing_bad++;
            if (pad_sel_o) rel_run = 0;
            if (sda_oe_o) sda_drv++;
            if ((rd_req_o && !pad_sel_o) || (scl_oe_o && pad_sel_o)) mode_bad++;
            if (done_o) done_cnt++;
            if (fail_o) fail_cnt++;
            if (!slave_pwr_en_o && !busy_o) busy_bad++;
            if (!slave_pwr_en_o) pwr_run++;
            if (slave_pwr_en_o && !pwr_prev) begin
                pwr_pulses++;
                pwr_len = pwr_run;
                pwr_run = 0;
            end
            scl_prev = scl_oe_o; pad_prev = pad_sel_o; pwr_prev = slave_pwr_en_o;
        end
    end

    // controller model: answers each read after a short latency
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req_o) begin
                if (rd_addr_o != 7'h1A) addr_bad++;
                repeat (3) @(negedge clk);
                rd_ack_i  = (reads >= ack_from);
                rd_done_i = 1;
                reads++;
                @(negedge clk);
                rd_done_i = 0;
                rd_ack_i  = 0;
            end
        end
    end

    task automatic run_seq(input bit use_resume, input bit stuck, input int af, input bit poke);
        clear_stats();
        sda_stuck = stuck;
        ack_from  = af;
        @(negedge clk);
        if (use_resume) resume_i = 1; else start_i = 1;
        @(negedge clk);
        resume_i = 0; start_i = 0;
        chk(busy_o == 1, "R11 busy after launch", busy_o, 1);
        chk(pad_sel_o == 0, "R2 direct drive after launch", pad_sel_o, 0);
        for (int k = 0; k < 20000 && busy_o; k++) begin
            @(negedge clk);
            if (poke && k == 30) start_i = 1;
            if (poke && k == 31) start_i = 0;
            if (poke && k == 60) resume_i = 1;
            if (poke && k == 61) resume_i = 0;
        end
        repeat (3) @(negedge clk);
        sda_stuck = 0;
        chk(busy_o == 0, "R11 busy low at end", busy_o, 0);
        chk(timing_bad == 0, "R3 phase timing", timing_bad, 0);
        chk(mode_bad == 0, "R4 pad ownership", mode_bad, 0);
        chk(sda_drv == 0, "R3 sda released", sda_drv, 0);
        chk(busy_bad == 0, "R11 busy during power off", busy_bad, 0);
        chk(addr_bad == 0, "R5 read address 0x1A", addr_bad, 0);
    endtask

    task automatic t_reset();
        chk(busy_o == 0 && done_o == 0 && fail_o == 0, "R1 status idle", busy_o, 0);
        chk(scl_oe_o == 0 && sda_oe_o == 0 && rd_req_o == 0, "R1 drives idle", scl_oe_o, 0);
        chk(pad_sel_o == 1 && slave_pwr_en_o == 1, "R1 pads and power", pad_sel_o, 1);
    endtask

    task automatic t_basic();
        run_seq(0, 0, 0, 0);
        chk(pulses == 8, "R3 eight pulses", pulses, 8);
        chk(reads == 2, "R5 dummy plus check read", reads, 2);
        chk(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
        chk(fail_cnt == 0, "R7 no fail", fail_cnt, 0);
        chk(pwr_pulses == 0, "R8 no power cycle", pwr_pulses, 0);
    endtask

    task automatic t_resume_dummy_nack();
        run_seq(1, 0, 1, 0);
        chk(pulses == 8, "R2 resume launches", pulses, 8);
        chk(reads == 2, "R5 dummy nack ignored reads", reads, 2);
        chk(done_cnt == 1, "R5 dummy nack ignored done", done_cnt, 1);
    endtask

    task automatic t_ignore();
        run_seq(0, 0, 0, 1);
        chk(pulses == 8, "R10 no restart pulses", pulses, 8);
        chk(done_cnt == 1, "R10 one completion", done_cnt, 1);
        chk(reads == 2, "R10 reads", reads, 2);
    endtask

    task automatic t_retry();
        run_seq(0, 0, 2, 0);
        chk(pulses == 16, "R8 second attempt pulses", pulses, 16);
        chk(reads == 4, "R8 second attempt reads", reads, 4);
        chk(done_cnt == 1, "R8 retry success", done_cnt, 1);
        chk(pwr_pulses == 0, "R8 no power cycle before limit", pwr_pulses, 0);
    endtask

    task automatic t_power_ok();
        run_seq(0, 0, 6, 0);
        chk(pwr_pulses == 1, "R8 one power cycle", pwr_pulses, 1);
        chk(pwr_len == OFF, "R8 power off length", pwr_len, OFF);
        chk(pulses == 32, "R9 post power attempt pulses", pulses, 32);
        chk(reads == 8, "R9 reads", reads, 8);
        chk(done_cnt == 1 && fail_cnt == 0, "R9 success after power", done_cnt, 1);
    endtask

    task automatic t_stuck();
        run_seq(0, 1, 0, 0);
        chk(reads == 0, "R6 no read while stuck", reads, 0);
        chk(pulses == 32, "R6 four attempts", pulses, 32);
        chk(pwr_pulses == 1 && pwr_len == OFF, "R8 stuck power cycle", pwr_len, OFF);
        chk(fail_cnt == 1, "R9 single fail pulse", fail_cnt, 1);
        chk(done_cnt == 0, "R9 no done", done_cnt, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_stats();
        ack_from = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_resume_dummy_nack();
        t_ignore();
        t_retry();
        t_power_ok();
        t_stuck();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule